// File: doc/BRIEF.md
# Status Register Block Protection Unit

This unit keeps the nonvolatile protection bits of a serial flash status register: a hardware-lock enable bit and a five-bit protection field. It turns the field into the lowest address of the locked upper region of the array. For each write request it decides whether the request may go ahead. The request can be a page program, a sector erase, a block erase, a chip erase or a status register update. The decision depends on that locked region, the write-enable latch and the write-protect pin. It also returns the status byte that a status read command shifts out.

The surrounding command logic presents a request kind and a target address and reads back the permit flag. A status update is handled in two steps. The new byte is staged while the device is still selected, and it is committed when chip select rises. If the write-protect pin becomes effective between the two steps, the staged update is dropped. Once it has been committed, the pin no longer affects it. All interfaces are plain level or pulse signals, because no data streams through the unit.

Top module: `sr_protect_unit`

## Requirements
- R1: After reset the hardware-lock enable bit and all five protection bits are 0: the status byte reads 8'h00 when the latch input and the busy input are both 0, and `lock_base` equals the array size (nothing is locked).
- R2: When `busy` is 0, the status byte is {hw-lock enable, P4, P3, P2, P1, P0, `wen`, 0}, from bit 7 down to bit 0. When `busy` is 1, it reads 8'hFF.
- R3: When P2..P0 = 000, P4:P3 selects the lowest locked address. 00 locks nothing (the array size, 80000h), 01 gives 7E000h, 10 gives 7C000h and 11 gives 78000h.
- R4: When P2..P0 is not 000, P4:P3 are ignored. 001 gives 70000h, 010 gives 60000h, 011 gives 40000h and 1xx gives 0 (the whole array is locked).
- R5: With `wen` = 1, a program (kind 0) is permitted exactly when the address is below `lock_base`. A sector erase (kind 1, 4 KiB sectors) is permitted exactly when the whole sector lies below `lock_base`.
- R6: With `wen` = 1, a block erase (kind 2, 64 KiB blocks) is permitted only when the whole block lies below `lock_base`. A block that is only partly locked is refused.
- R7: A chip erase (kind 3) is permitted when `wen` = 1 and `lock_base` is not 0. `lock_base` then gives the erase limit.
- R8: When `wen` = 0, no request of any kind is permitted, and a staged status update does not change the stored bits.
- R9: When the hardware-lock enable bit is 1 and `wp_n` is 0, status updates (kind 4) are refused. This includes any attempt to clear the enable bit itself.
- R10: When the hardware-lock enable bit is 0, the `wp_n` pin has no effect on status updates.
- R11: If the hardware lock becomes active between staging and commit, the staged update is dropped. A later commit then changes nothing.
- R12: After a commit has taken effect, a later fall of `wp_n` leaves the stored bits unchanged.
- R13: A status update stores only bits 7..2 of `sr_data`. Bits 1..0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the stored bits |
| wp_n | input | 1 | Write-protect pin, low = protect |
| wen | input | 1 | Write-enable latch state |
| busy | input | 1 | Internal write cycle in progress |
| req_kind | input | 3 | 0 program, 1 sector erase, 2 block erase, 3 chip erase, 4 status update |
| req_addr | input | ADDR_W (19) | Target byte address |
| permit | output | 1 | The request may proceed |
| lock_base | output | ADDR_W+1 (20) | Lowest locked address; equals the array size when nothing is locked |
| sr_stage | input | 1 | One-cycle pulse: stage `sr_data` as a pending update |
| sr_data | input | 8 | New status byte |
| sr_commit | input | 1 | One-cycle pulse: apply the pending update |
| status_rd | output | 8 | Status byte for read-back |

## Verification
The assertions take two things for granted. First, `sr_stage` and `sr_commit` arrive as separate pulses. Second, a commit follows its stage while `wen` is held steady. The bench drives each status update as a stage cycle followed by a commit cycle and never pulses both in the same cycle. It changes `wp_n` only on the falling clock edge, between the stage and the commit or after the commit. The permit assertions relate the combinational flag to `lock_base` and to the address. For this reason, every request that the bench presents uses an address inside the 19-bit array.

// File: rtl/sr_prot_pkg.sv
package sr_prot_pkg;
  typedef enum logic [2:0] {
    RQ_PROG  = 3'd0,
    RQ_SECT  = 3'd1,
    RQ_BLK   = 3'd2,
    RQ_CHIP  = 3'd3,
    RQ_STAT  = 3'd4
  } req_kind_e;

  typedef struct packed {
    logic       hw_en;
    logic [4:0] prot;
  } sr_bits_t;
endpackage

// File: rtl/bp_lock_decode.sv
module bp_lock_decode #(
  parameter int ADDR_W = 19
) (
  input  logic [4:0]      prot,
  output logic [ADDR_W:0] lock_base
);
  localparam logic [ADDR_W:0] SIZE = {1'b1, {ADDR_W{1'b0}}};

  always_comb begin
    lock_base = SIZE;
    if (prot[2]) begin
      lock_base = '0;
    end else begin
      unique case (prot[1:0])
        2'b11: lock_base = SIZE - (SIZE >> 1);
        2'b10: lock_base = SIZE - (SIZE >> 2);
        2'b01: lock_base = SIZE - (SIZE >> 3);
        default: begin
          unique case (prot[4:3])
            2'b11:   lock_base = SIZE - (SIZE >> 4);
            2'b10:   lock_base = SIZE - (SIZE >> 5);
            2'b01:   lock_base = SIZE - (SIZE >> 6);
            default: lock_base = SIZE;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/prot_gate.sv
module prot_gate
  import sr_prot_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int SECTOR_W = 12,
  parameter int BLOCK_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wen,
  input  logic              wp_n,
  input  logic              hw_en,
  input  logic [ADDR_W:0]   lock_base,
  input  logic [2:0]        kind,
  input  logic [ADDR_W-1:0] addr,
  output logic              permit,
  output logic              sr_ok
);
  localparam logic [ADDR_W:0] SECT_SPAN = {{(ADDR_W-SECTOR_W){1'b0}}, 1'b1, {SECTOR_W{1'b0}}};
  localparam logic [ADDR_W:0] BLK_SPAN  = {{(ADDR_W-BLOCK_W){1'b0}}, 1'b1, {BLOCK_W{1'b0}}};

  logic [ADDR_W:0] byte_pos, sect_end, blk_end;
  logic            hw_lock;
  req_kind_e       k;

  assign k        = req_kind_e'(kind);
  assign byte_pos = {1'b0, addr};
  assign sect_end = {1'b0, addr[ADDR_W-1:SECTOR_W], {SECTOR_W{1'b0}}} + SECT_SPAN;
  assign blk_end  = {1'b0, addr[ADDR_W-1:BLOCK_W], {BLOCK_W{1'b0}}} + BLK_SPAN;
  assign hw_lock  = hw_en & ~wp_n;
  assign sr_ok    = wen & ~hw_lock;

  always_comb begin
    permit = 1'b0;
    if (wen) begin
      unique case (k)
        RQ_PROG: permit = byte_pos < lock_base;
        RQ_SECT: permit = sect_end <= lock_base;
        RQ_BLK:  permit = blk_end <= lock_base;
        RQ_CHIP: permit = lock_base != '0;
        RQ_STAT: permit = sr_ok;
        default: permit = 1'b0;
      endcase
    end
  end

  AST_PROG_BELOW_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (permit && kind == 3'd0) |-> (byte_pos < lock_base)); // R5
  AST_BLK_FULLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (permit && kind == 3'd2) |-> (blk_end <= lock_base)); // R6
  AST_CHIP_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    (permit && kind == 3'd3) |-> (lock_base != '0)); // R7
endmodule

// File: rtl/status_store.sv
module status_store
  import sr_prot_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wp_n,
  input  logic       sr_ok,
  input  logic       stage,
  input  logic [7:0] data,
  input  logic       commit,
  output sr_bits_t   bits
);
  sr_bits_t staged;
  logic     pending;
  logic     hw_lock;

  assign hw_lock = bits.hw_en & ~wp_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits    <= '0;
      staged  <= '0;
      pending <= 1'b0;
    end else if (commit) begin
      pending <= 1'b0;
      if (pending && !hw_lock) bits <= staged;
    end else if (stage) begin
      pending <= sr_ok;
      staged  <= sr_bits_t'(data[7:2]);
    end else if (hw_lock) begin
      pending <= 1'b0;
    end
  end

  AST_CHANGE_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bits != $past(bits)) |-> $past(commit && pending)); // R11
  AST_HW_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bits.hw_en && !wp_n) |-> bits.hw_en); // R9
  AST_CANCEL_ON_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && hw_lock && !stage) |=> !pending); // R11
endmodule

// File: rtl/sr_protect_unit.sv
module sr_protect_unit
  import sr_prot_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int SECTOR_W = 12,
  parameter int BLOCK_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              wen,
  input  logic              busy,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              permit,
  output logic [ADDR_W:0]   lock_base,
  input  logic              sr_stage,
  input  logic [7:0]        sr_data,
  input  logic              sr_commit,
  output logic [7:0]        status_rd
);
  sr_bits_t bits;
  logic     sr_ok;

  status_store u_store (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .sr_ok(sr_ok),
    .stage(sr_stage), .data(sr_data), .commit(sr_commit), .bits(bits)
  );

  bp_lock_decode #(.ADDR_W(ADDR_W)) u_dec (
    .prot(bits.prot), .lock_base(lock_base)
  );

  prot_gate #(.ADDR_W(ADDR_W), .SECTOR_W(SECTOR_W), .BLOCK_W(BLOCK_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .wen(wen), .wp_n(wp_n), .hw_en(bits.hw_en),
    .lock_base(lock_base), .kind(req_kind), .addr(req_addr),
    .permit(permit), .sr_ok(sr_ok)
  );

  assign status_rd = busy ? 8'hFF : {bits.hw_en, bits.prot, wen, 1'b0};

  AST_NO_PERMIT_WO_WEN: assert property (@(posedge clk) disable iff (!rst_n)
    !wen |-> !permit); // R8
  AST_STAT_REFUSED_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd[7] && !busy && !wp_n && req_kind == 3'd4) |-> !permit); // R9
endmodule

// File: tb/test_sr_protect_unit.sv
module test_sr_protect_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wp_n = 1'b1;
  logic        wen = 1'b0;
  logic        busy = 1'b0;
  logic [2:0]  req_kind = 3'd0;
  logic [18:0] req_addr = '0;
  logic        permit;
  logic [19:0] lock_base;
  logic        sr_stage = 1'b0;
  logic [7:0]  sr_data = '0;
  logic        sr_commit = 1'b0;
  logic [7:0]  status_rd;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  sr_protect_unit i_sr_protect_unit (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .wen(wen), .busy(busy),
    .req_kind(req_kind), .req_addr(req_addr), .permit(permit),
    .lock_base(lock_base), .sr_stage(sr_stage), .sr_data(sr_data),
    .sr_commit(sr_commit), .status_rd(status_rd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_sr(input logic [7:0] d);
    @(negedge clk); sr_data = d; sr_stage = 1'b1;
    @(negedge clk); sr_stage = 1'b0; sr_commit = 1'b1;
    @(negedge clk); sr_commit = 1'b0;
  endtask

  task automatic ask(input logic [2:0] k, input logic [18:0] a, input logic exp, input string req);
    @(negedge clk); req_kind = k; req_addr = a; #1;
    chk(req, permit, exp);
  endtask

  task automatic t_reset;
    #1;
    chk("R1 status", status_rd, 8'h00);
    chk("R1 lock_base", lock_base, 20'h80000);
  endtask

  task automatic t_layout;
    @(negedge clk); wen = 1'b1; #1;
    chk("R2 wen bit", status_rd, 8'h02);
    busy = 1'b1; #1;
    chk("R2 busy ones", status_rd, 8'hFF);
    busy = 1'b0;
    write_sr(8'hA8); #1;
    chk("R2 layout", status_rd, 8'hAA);
    write_sr(8'h00);
  endtask

  task automatic t_decode;
    logic [7:0]  codes [12] = '{8'h00, 8'h20, 8'h40, 8'h60, 8'h04, 8'h64,
                                8'h08, 8'h48, 8'h0C, 8'h10, 8'h7C, 8'h14};
    logic [19:0] bases [12] = '{20'h80000, 20'h7E000, 20'h7C000, 20'h78000,
                                20'h70000, 20'h70000, 20'h60000, 20'h60000,
                                20'h40000, 20'h0, 20'h0, 20'h0};
    for (int i = 0; i < 12; i++) begin
      write_sr(codes[i]); #1;
      if (i < 4) chk("R3 decode", lock_base, bases[i]);
      else       chk("R4 decode", lock_base, bases[i]);
    end
  endtask

  task automatic t_low_bits;
    write_sr(8'h03); #1;
    chk("R13 low bits ignored", status_rd, 8'h02);
  endtask

  task automatic t_prog_sector;
    write_sr(8'h04);
    ask(3'd0, 19'h6FFFF, 1'b1, "R5 prog below");
    ask(3'd0, 19'h70000, 1'b0, "R5 prog at base");
    ask(3'd1, 19'h6F123, 1'b1, "R5 sector free");
    ask(3'd1, 19'h70800, 1'b0, "R5 sector locked");
  endtask

  task automatic t_block;
    write_sr(8'h20);
    ask(3'd2, 19'h70010, 1'b0, "R6 block partly locked");
    ask(3'd2, 19'h60000, 1'b1, "R6 block free");
    ask(3'd1, 19'h7D000, 1'b1, "R5 sector under 1/64");
    ask(3'd1, 19'h7E100, 1'b0, "R5 sector in 1/64");
  endtask

  task automatic t_chip;
    ask(3'd3, 19'h0, 1'b1, "R7 chip allowed");
    chk("R7 erase limit", lock_base, 20'h7E000);
    write_sr(8'h10);
    ask(3'd3, 19'h0, 1'b0, "R7 chip all locked");
    write_sr(8'h00);
  endtask

  task automatic t_no_wen;
    @(negedge clk); wen = 1'b0;
    ask(3'd0, 19'h0, 1'b0, "R8 prog no wen");
    ask(3'd4, 19'h0, 1'b0, "R8 status no wen");
    write_sr(8'h1C); #1;
    chk("R8 status unchanged", status_rd, 8'h00);
    @(negedge clk); wen = 1'b1;
  endtask

  task automatic t_hw_lock;
    write_sr(8'h84);
    @(negedge clk); wp_n = 1'b0;
    ask(3'd4, 19'h0, 1'b0, "R9 status refused");
    ask(3'd0, 19'h10, 1'b1, "R9 array still writable");
    write_sr(8'h00); #1;
    chk("R9 enable kept", status_rd, 8'h86);
    @(negedge clk); wp_n = 1'b1;
    write_sr(8'h00); #1;
    chk("R9 cleared with pin high", status_rd, 8'h02);
  endtask

  task automatic t_pin_ignored;
    @(negedge clk); wp_n = 1'b0;
    ask(3'd4, 19'h0, 1'b1, "R10 status allowed");
    write_sr(8'h08); #1;
    chk("R10 written", status_rd, 8'h0A);
    @(negedge clk); wp_n = 1'b1;
    write_sr(8'h00);
  endtask

  task automatic t_cancel;
    write_sr(8'h80);
    @(negedge clk); sr_data = 8'h84; sr_stage = 1'b1;
    @(negedge clk); sr_stage = 1'b0; wp_n = 1'b0;
    @(negedge clk); wp_n = 1'b1;
    @(negedge clk); sr_commit = 1'b1;
    @(negedge clk); sr_commit = 1'b0; #1;
    chk("R11 cancelled", status_rd, 8'h82);
  endtask

  task automatic t_after_commit;
    write_sr(8'h88);
    @(negedge clk); wp_n = 1'b0;
    @(negedge clk); @(negedge clk); #1;
    chk("R12 kept", status_rd, 8'h8A);
    wp_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_layout();
    t_decode();
    t_low_bits();
    t_prog_sector();
    t_block();
    t_chip();
    t_no_wen();
    t_hw_lock();
    t_pin_ignored();
    t_cancel();
    t_after_commit();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule